// File: doc/BRIEF.md
# Ethernet MAC Loopback Router with Frame Check Sequence Control

This block sits between the transmit byte stream of a 10 Mb/s Ethernet MAC, the network receive stream and the MAC receiver. It appends the CRC-32 frame check sequence to outgoing frames. Software can switch this off and supply the four check bytes itself. The block then steers the resulting stream according to three mode inputs. With loopback off, frames go to the line and the receiver listens only to the network. In internal loopback, the line stays silent, network traffic is shut out, and the transmitted stream is handed to the receiver at one of two points. The first point is right at the MAC. The second is after the encoder/decoder path, which is modelled as a fixed pipeline delay. In external loopback, frames leave on the line as usual and the receiver keeps listening to the network, which is expected to return them.

A receive CRC checker runs in every mode. It reports whether each frame's check sequence is intact, and it produces the multicast hash index from the CRC register after the destination address. Whenever any loopback mode is on, the block forces short-frame acceptance. The runt-accept register bit is only an input here, so the block never changes the stored value. Frames of any length, down to a single byte, pass through each path.

Top module: `lbk_top`

## Requirements
- R1: With loop_en low, the line output carries the transmit stream, and the receiver output carries only the network stream. A transmit byte appears on the line one cycle after it is accepted.
- R2: With tx_fcs_off low, the block appends four check bytes after the last frame byte, least significant byte first. They are the CRC-32 over the frame: reflected polynomial 0xEDB88320, initial value all ones, result complemented. Only the final check byte carries the last flag. tx_ready is low for exactly four cycles after the last byte is accepted.
- R3: With tx_fcs_off high, the frame passes unchanged, with no extra bytes and the last flag on its final byte, and tx_ready stays high.
- R4: With loop_en=1, int_loop=1 and codec_in_loop=0 (MAC point), the receiver output carries the transmitted stream, including any appended check bytes, one cycle after acceptance. The line output stays idle.
- R5: With loop_en=1, int_loop=1 and codec_in_loop=1 (codec point), the receiver output carries the transmitted stream CODEC_LAT cycles later than at the MAC point. The line output stays idle.
- R6: In either internal loopback mode, bytes offered on the network input never reach the receiver output.
- R7: With loop_en=1 and int_loop=0 (external loopback), the line output carries the transmit stream and the receiver output carries the network stream.
- R8: The receive checker runs in every mode. One cycle after each receiver-output last byte, rx_fcs_done pulses. At that pulse, rx_fcs_ok is 1 exactly when the running CRC register, after the last byte, equals 0xDEBB20E3.
- R9: One cycle after the sixth receiver-output byte of a frame, rx_hash_valid pulses and rx_hash holds bits [31:26] of the running CRC register (not complemented) after that byte. Frames shorter than six bytes give no hash.
- R10: runt_accept equals rpa_reg when loop_en is low, and is 1 whenever loop_en is high.
- R11: A one-byte frame is looped back with its four check bytes, giving five bytes at the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | Loopback enable |
| codec_in_loop | input | 1 | Internal loop taken after the codec path |
| int_loop | input | 1 | Internal (1) or external (0) loopback |
| tx_fcs_off | input | 1 | Suppress appended check sequence |
| rpa_reg | input | 1 | Stored runt-accept setting |
| tx_valid | input | 1 | Transmit byte valid |
| tx_last | input | 1 | Transmit byte ends frame |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Block can accept a transmit byte |
| net_valid | input | 1 | Network byte valid |
| net_last | input | 1 | Network byte ends frame |
| net_data | input | 8 | Network byte |
| line_valid | output | 1 | Line byte valid |
| line_last | output | 1 | Line byte ends frame |
| line_data | output | 8 | Line byte |
| rx_valid | output | 1 | Receiver byte valid |
| rx_last | output | 1 | Receiver byte ends frame |
| rx_data | output | 8 | Receiver byte |
| rx_fcs_done | output | 1 | Frame check result strobe |
| rx_fcs_ok | output | 1 | Check sequence intact |
| rx_hash_valid | output | 1 | Hash index strobe |
| rx_hash | output | 6 | Multicast hash index |
| runt_accept | output | 1 | Effective runt acceptance |

## Verification
The hardest case to reach from the ports is the internal loopback with network traffic arriving at the same moment. To cover it, the bench drives a transmit frame and a different network frame in parallel. It then confirms that the receiver sees only the transmitted bytes and their check sequence, and that the line stays silent. The codec-point delay is measured from cycle stamps against the MAC-point run. The checker's verdict is exercised both on looped-back frames and on a network frame whose check bytes are corrupted.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic [7:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        PATH_NORMAL,
        PATH_EXTERNAL,
        PATH_INT_MAC,
        PATH_INT_CODEC
    } path_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;
    localparam int          FCS_BYTES     = 4;

    function automatic logic [31:0] crc_byte(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic path_e decode_path(logic loop, logic codec, logic intl);
        if (!loop)     return PATH_NORMAL;
        else if (!intl) return PATH_EXTERNAL;
        else if (codec) return PATH_INT_CODEC;
        else            return PATH_INT_MAC;
    endfunction

endpackage

// File: rtl/lbk_tx_fcs.sv
module lbk_tx_fcs
    import lbk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fcs_off,
    input  logic        in_valid,
    input  logic        in_last,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output beat_t       out_beat
);
    localparam int CNT_W = $clog2(FCS_BYTES + 1);

    logic [CNT_W-1:0] left;
    logic [31:0]      crc;
    logic [31:0]      fcs;
    logic [31:0]      crc_nx;
    logic             take;

    assign in_ready = (left == '0);
    assign take     = in_valid && in_ready;
    assign crc_nx   = crc_byte(crc, in_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            left     <= '0;
            crc      <= CRC_INIT;
            fcs      <= '0;
            out_beat <= '0;
        end else if (take) begin
            out_beat <= '{valid: 1'b1, last: in_last && fcs_off, data: in_data};
            if (in_last) begin
                crc <= CRC_INIT;
                if (!fcs_off) begin
                    fcs  <= ~crc_nx;
                    left <= CNT_W'(FCS_BYTES);
                end
            end else begin
                crc <= crc_nx;
            end
        end else if (left != '0) begin
            out_beat <= '{valid: 1'b1, last: (left == CNT_W'(1)), data: fcs[7:0]};
            fcs      <= fcs >> 8;
            left     <= left - CNT_W'(1);
        end else begin
            out_beat <= '0;
        end
    end

endmodule

// File: rtl/lbk_path_mux.sv
module lbk_path_mux
    import lbk_pkg::*;
#(
    parameter int CODEC_LAT = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  path_e path,
    input  beat_t tx_beat,
    input  beat_t net_beat,
    output beat_t line_beat,
    output beat_t rx_beat
);
    beat_t codec_beat;

    generate
        if (CODEC_LAT == 0) begin : g_no_delay
            assign codec_beat = tx_beat;
        end else begin : g_delay
            beat_t dly [CODEC_LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < CODEC_LAT; i++) dly[i] <= '0;
                end else begin
                    dly[0] <= tx_beat;
                    for (int i = 1; i < CODEC_LAT; i++) dly[i] <= dly[i-1];
                end
            end
            assign codec_beat = dly[CODEC_LAT-1];
        end
    endgenerate

    always_comb begin
        line_beat = '0;
        rx_beat   = '0;
        unique case (path)
            PATH_NORMAL, PATH_EXTERNAL: begin
                line_beat = tx_beat;
                rx_beat   = net_beat;
            end
            PATH_INT_MAC:   rx_beat = tx_beat;
            PATH_INT_CODEC: rx_beat = codec_beat;
            default: ;
        endcase
    end

endmodule

// File: rtl/lbk_rx_check.sv
module lbk_rx_check
    import lbk_pkg::*;
#(
    parameter int HASH_AT = 6,
    parameter int HASH_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             rx_beat,
    output logic              fcs_done,
    output logic              fcs_ok,
    output logic              hash_valid,
    output logic [HASH_W-1:0] hash
);
    localparam int POS_W = $clog2(HASH_AT + 1);

    logic [31:0]      crc;
    logic [31:0]      crc_nx;
    logic [POS_W-1:0] pos;

    assign crc_nx = crc_byte(crc, rx_beat.data);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc        <= CRC_INIT;
            pos        <= '0;
            fcs_done   <= 1'b0;
            fcs_ok     <= 1'b0;
            hash_valid <= 1'b0;
            hash       <= '0;
        end else begin
            fcs_done   <= 1'b0;
            hash_valid <= 1'b0;
            if (rx_beat.valid) begin
                if (pos == POS_W'(HASH_AT - 1)) begin
                    hash_valid <= 1'b1;
                    hash       <= crc_nx[31 -: HASH_W];
                end
                if (rx_beat.last) begin
                    fcs_done <= 1'b1;
                    fcs_ok   <= (crc_nx == CRC_RESIDUE);
                    crc      <= CRC_INIT;
                    pos      <= '0;
                end else begin
                    crc <= crc_nx;
                    if (pos < POS_W'(HASH_AT)) pos <= pos + POS_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/lbk_top.sv
module lbk_top
    import lbk_pkg::*;
#(
    parameter int CODEC_LAT = 2,
    parameter int HASH_AT   = 6,
    parameter int HASH_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en,
    input  logic              codec_in_loop,
    input  logic              int_loop,
    input  logic              tx_fcs_off,
    input  logic              rpa_reg,
    input  logic              tx_valid,
    input  logic              tx_last,
    input  logic [7:0]        tx_data,
    output logic              tx_ready,
    input  logic              net_valid,
    input  logic              net_last,
    input  logic [7:0]        net_data,
    output logic              line_valid,
    output logic              line_last,
    output logic [7:0]        line_data,
    output logic              rx_valid,
    output logic              rx_last,
    output logic [7:0]        rx_data,
    output logic              rx_fcs_done,
    output logic              rx_fcs_ok,
    output logic              rx_hash_valid,
    output logic [HASH_W-1:0] rx_hash,
    output logic              runt_accept
);
    beat_t tx_beat;
    beat_t net_beat;
    beat_t line_beat;
    beat_t rx_beat;
    path_e path;

    assign path     = decode_path(loop_en, codec_in_loop, int_loop);
    assign net_beat = '{valid: net_valid, last: net_last, data: net_data};

    lbk_tx_fcs u_tx_fcs (
        .clk      (clk),
        .rst      (rst),
        .fcs_off  (tx_fcs_off),
        .in_valid (tx_valid),
        .in_last  (tx_last),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .out_beat (tx_beat)
    );

    lbk_path_mux #(.CODEC_LAT(CODEC_LAT)) u_path (
        .clk       (clk),
        .rst       (rst),
        .path      (path),
        .tx_beat   (tx_beat),
        .net_beat  (net_beat),
        .line_beat (line_beat),
        .rx_beat   (rx_beat)
    );

    lbk_rx_check #(.HASH_AT(HASH_AT), .HASH_W(HASH_W)) u_rx_check (
        .clk        (clk),
        .rst        (rst),
        .rx_beat    (rx_beat),
        .fcs_done   (rx_fcs_done),
        .fcs_ok     (rx_fcs_ok),
        .hash_valid (rx_hash_valid),
        .hash       (rx_hash)
    );

    assign line_valid  = line_beat.valid;
    assign line_last   = line_beat.last;
    assign line_data   = line_beat.data;
    assign rx_valid    = rx_beat.valid;
    assign rx_last     = rx_beat.last;
    assign rx_data     = rx_beat.data;
    assign runt_accept = rpa_reg | loop_en;

endmodule

// File: rtl/lbk_checker.sv
module lbk_checker (
    input logic clk,
    input logic rst,
    input logic loop_en,
    input logic int_loop,
    input logic tx_fcs_off,
    input logic rpa_reg,
    input logic tx_valid,
    input logic tx_last,
    input logic tx_ready,
    input logic line_valid,
    input logic rx_valid,
    input logic rx_last,
    input logic rx_fcs_done,
    input logic runt_accept
);
    AST_FCS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last && !tx_fcs_off) |=> !tx_ready); // R2

    AST_NORMAL_LINE_FILLED: assert property (@(posedge clk) disable iff (rst)
        (!loop_en && !tx_ready) |-> line_valid); // R2

    AST_NOFCS_READY: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last && tx_fcs_off) |=> tx_ready); // R3

    AST_INT_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (loop_en && int_loop) |-> !line_valid); // R4

    AST_CHECK_STROBE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_last) |=> rx_fcs_done); // R8

    AST_RUNT_FORCED: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> runt_accept); // R10

    AST_RUNT_FOLLOWS_REG: assert property (@(posedge clk) disable iff (rst)
        !loop_en |-> (runt_accept == rpa_reg)); // R10
endmodule

bind lbk_top lbk_checker u_lbk_checker (
    .clk         (clk),
    .rst         (rst),
    .loop_en     (loop_en),
    .int_loop    (int_loop),
    .tx_fcs_off  (tx_fcs_off),
    .rpa_reg     (rpa_reg),
    .tx_valid    (tx_valid),
    .tx_last     (tx_last),
    .tx_ready    (tx_ready),
    .line_valid  (line_valid),
    .rx_valid    (rx_valid),
    .rx_last     (rx_last),
    .rx_fcs_done (rx_fcs_done),
    .runt_accept (runt_accept)
);

// File: tb/test_lbk_top.sv
`timescale 1ns/1ps
module test_lbk_top;
    typedef logic [7:0] bq_t[$];
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic loop_en = 0, codec_in_loop = 0, int_loop = 0, tx_fcs_off = 0, rpa_reg = 0;
    logic tx_valid = 0, tx_last = 0;
    logic [7:0] tx_data = '0;
    logic net_valid = 0, net_last = 0;
    logic [7:0] net_data = '0;
    logic tx_ready, line_valid, line_last, rx_valid, rx_last;
    logic [7:0] line_data, rx_data;
    logic rx_fcs_done, rx_fcs_ok, rx_hash_valid, runt_accept;
    logic [5:0] rx_hash;

    int checks = 0, errors = 0;
    int cyc = 0, tx_start = 0;
    bq_t line_q, rx_q;
    int line_lasts, rx_lasts, line_first, rx_first, busy, n_done, n_hash;
    logic last_ok;
    logic [5:0] last_hash;

    always #2.5 clk = ~clk;

    lbk_top #(.CODEC_LAT(LAT)) i_lbk_top (
        .clk(clk), .rst(rst), .loop_en(loop_en), .codec_in_loop(codec_in_loop),
        .int_loop(int_loop), .tx_fcs_off(tx_fcs_off), .rpa_reg(rpa_reg),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_data(tx_data), .tx_ready(tx_ready),
        .net_valid(net_valid), .net_last(net_last), .net_data(net_data),
        .line_valid(line_valid), .line_last(line_last), .line_data(line_data),
        .rx_valid(rx_valid), .rx_last(rx_last), .rx_data(rx_data),
        .rx_fcs_done(rx_fcs_done), .rx_fcs_ok(rx_fcs_ok),
        .rx_hash_valid(rx_hash_valid), .rx_hash(rx_hash), .runt_accept(runt_accept)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) if (!rst) begin
        if (line_valid) begin
            if (line_first < 0) line_first = cyc;
            line_q.push_back(line_data);
            if (line_last) line_lasts++;
        end
        if (rx_valid) begin
            if (rx_first < 0) rx_first = cyc;
            rx_q.push_back(rx_data);
            if (rx_last) rx_lasts++;
        end
        if (!tx_ready) busy++;
        if (rx_fcs_done) begin n_done++; last_ok = rx_fcs_ok; end
        if (rx_hash_valid) begin n_hash++; last_hash = rx_hash; end
    end

    function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] d);
        for (int b = 0; b < 8; b++)
            c = (c[0] ^ d[b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    function automatic bq_t with_fcs(bq_t f);
        logic [31:0] c = 32'hFFFF_FFFF;
        bq_t r = f;
        foreach (f[i]) c = crc_upd(c, f[i]);
        c = ~c;
        for (int k = 0; k < 4; k++) r.push_back(c[8*k +: 8]);
        return r;
    endfunction

    function automatic logic [5:0] exp_hash(bq_t f);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) c = crc_upd(c, f[i]);
        return c[31:26];
    endfunction

    function automatic bq_t mk_frame(int n, int seed);
        bq_t r;
        for (int i = 0; i < n; i++) r.push_back(8'(seed + i * 7));
        return r;
    endfunction

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_q(string req, bq_t act, bq_t exp);
        checks++;
        if (act.size() != exp.size()) begin
            errors++;
            $display("FAIL %s: actual length %0d expected length %0d", req, act.size(), exp.size());
        end else begin
            foreach (exp[i]) if (act[i] !== exp[i]) begin
                errors++;
                $display("FAIL %s: byte %0d actual %02h expected %02h", req, i, act[i], exp[i]);
                break;
            end
        end
    endtask

    task automatic clear_mon();
        line_q.delete(); rx_q.delete();
        line_lasts = 0; rx_lasts = 0; line_first = -1; rx_first = -1;
        busy = 0; n_done = 0; n_hash = 0; last_ok = 0; last_hash = '0;
    endtask

    task automatic set_mode(logic l, logic c, logic i, logic off);
        @(posedge clk); #1;
        loop_en = l; codec_in_loop = c; int_loop = i; tx_fcs_off = off;
        repeat (LAT + 2) @(posedge clk);
        #1 clear_mon();
    endtask

    task automatic send_tx(bq_t f);
        @(posedge clk); #1;
        tx_start = cyc;
        foreach (f[i]) begin
            tx_valid = 1; tx_data = f[i]; tx_last = (i == f.size() - 1);
            @(posedge clk); #1;
        end
        tx_valid = 0; tx_last = 0;
    endtask

    task automatic send_net(bq_t f);
        @(posedge clk); #1;
        foreach (f[i]) begin
            net_valid = 1; net_data = f[i]; net_last = (i == f.size() - 1);
            @(posedge clk); #1;
        end
        net_valid = 0; net_last = 0;
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1 reset line_valid", line_valid, 0);
        check_eq("R1 reset rx_valid", rx_valid, 0);
        check_eq("R2 reset tx_ready", tx_ready, 1);
        check_eq("R10 reset runt_accept", runt_accept, 0);
    endtask

    task automatic t_normal();
        bq_t tf = mk_frame(10, 3);
        bq_t nf = with_fcs(mk_frame(8, 40));
        set_mode(0, 0, 0, 0);
        fork send_tx(tf); send_net(nf); join
        settle();
        check_q("R1 R2 normal line stream", line_q, with_fcs(tf));
        check_eq("R2 single last flag on line", line_lasts, 1);
        check_eq("R2 ready low cycles", busy, 4);
        check_eq("R1 line latency", line_first - tx_start, 1);
        check_q("R1 receiver gets network only", rx_q, nf);
        check_eq("R8 good network frame", last_ok, 1);
        check_eq("R8 one strobe", n_done, 1);
        check_eq("R9 hash strobe", n_hash, 1);
        check_eq("R9 hash value", last_hash, exp_hash(nf));
    endtask

    task automatic t_fcs_off();
        bq_t tf = with_fcs(mk_frame(7, 90));
        set_mode(0, 0, 0, 1);
        send_tx(tf);
        settle();
        check_q("R3 frame unchanged", line_q, tf);
        check_eq("R3 last flag", line_lasts, 1);
        check_eq("R3 ready stays high", busy, 0);
    endtask

    task automatic t_int(logic codec);
        bq_t tf = mk_frame(12, codec ? 17 : 5);
        bq_t nf = with_fcs(mk_frame(9, 200));
        set_mode(1, codec, 1, 0);
        fork send_tx(tf); send_net(nf); join
        settle();
        if (!codec) begin
            check_q("R4 R6 MAC point receiver stream", rx_q, with_fcs(tf));
            check_eq("R4 line idle", line_q.size(), 0);
            check_eq("R4 latency", rx_first - tx_start, 1);
        end else begin
            check_q("R5 R6 codec point receiver stream", rx_q, with_fcs(tf));
            check_eq("R5 line idle", line_q.size(), 0);
            check_eq("R5 latency", rx_first - tx_start, 1 + LAT);
        end
        check_eq("R6 one frame only", rx_lasts, 1);
        check_eq("R8 looped frame checks good", last_ok, 1);
        check_eq("R9 hash from looped frame", last_hash, exp_hash(tf));
    endtask

    task automatic t_ext();
        bq_t tf = mk_frame(6, 77);
        bq_t nf = with_fcs(mk_frame(11, 9));
        set_mode(1, 0, 0, 0);
        fork send_tx(tf); send_net(nf); join
        settle();
        check_q("R7 line carries transmit", line_q, with_fcs(tf));
        check_q("R7 receiver carries network", rx_q, nf);
        check_eq("R10 forced in external", runt_accept, 1);
    endtask

    task automatic t_bad_fcs();
        bq_t nf = with_fcs(mk_frame(8, 123));
        nf[nf.size() - 2] = nf[nf.size() - 2] ^ 8'h10;
        set_mode(0, 0, 0, 0);
        send_net(nf);
        settle();
        check_eq("R8 corrupt frame strobe", n_done, 1);
        check_eq("R8 corrupt frame flagged", last_ok, 0);
    endtask

    task automatic t_short();
        bq_t tf = mk_frame(1, 66);
        set_mode(1, 0, 1, 0);
        send_tx(tf);
        settle();
        check_q("R11 one-byte frame looped", rx_q, with_fcs(tf));
        check_eq("R9 no hash for five bytes", n_hash, 0);
        check_eq("R11 checked good", last_ok, 1);
    endtask

    task automatic t_runt();
        set_mode(0, 0, 0, 0);
        rpa_reg = 1; @(negedge clk);
        check_eq("R10 follows reg high", runt_accept, 1);
        rpa_reg = 0; @(negedge clk);
        check_eq("R10 follows reg low", runt_accept, 0);
        loop_en = 1; int_loop = 1; @(negedge clk);
        check_eq("R10 forced internal", runt_accept, 1);
        loop_en = 0; int_loop = 0; @(negedge clk);
        check_eq("R10 reg untouched", runt_accept, 0);
    endtask

    initial begin
        clear_mon();
        repeat (4) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_normal();
        t_fcs_off();
        t_int(0);
        t_int(1);
        t_ext();
        t_bad_fcs();
        t_short();
        t_runt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule